// File: doc/BRIEF.md
# Pipelined Converter Digital Correction Back End

This block is the digital tail of a pipelined analog-to-digital converter. The converter is built from six redundant 2-bit subconverter stages and a closing 2-bit flash. On every sample clock the block takes one 2-bit code from each stage. Those codes belong to different input samples, because a sample moves one stage further every half clock.

Each lane gets its own delay, so all seven codes for one sample arrive together. The aligned codes are merged with one bit of overlap between neighbours and clamped to the 8-bit range. The result then passes through two output register levels before it reaches the bus.

A format input picks between offset binary and two's complement. An output-disable input is turned into a drive-enable signal for the pads. A valid flag stays low until the power-up window and the pipeline latency have both passed.

Top module: `adc_corr_backend`

## Requirements
- R1: Stage i (0 = first) presents its code on `stageCodes[2i+1:2i]`. If stage 0 delivers sample n at rising edge s, stage i delivers it at edge s + floor(i/2), and the flash delivers it on `flashCode` at edge s + 3.
- R2: The merged value of a sample is raw = Σ_{i=0..5} code_i·2^(6−i) + flash − 63.
- R3: The stored word is 0 when raw < 0 and 255 when raw > 255. Otherwise it is raw.
- R4: The word for a sample appears on `dataOut` after the 7th rising edge that follows edge s.
- R5: With codes changing on every clock, a new correct word appears on `dataOut` after every rising edge.
- R6: `fmtTwos` is sampled at the edge that loads `dataOut`. When it is 0 the output is offset binary, the stored word itself. When it is 1 the output is two's complement, the stored word with bit 7 inverted.
- R7: `dataDrive` is the inverse of `outDisable` within the same cycle. While the output is disabled the pipeline keeps running, and `dataOut` keeps carrying the correct words.
- R8: After reset is released, `dataValid` stays 0 through the first 26 rising edges. It is 1 after the 27th edge, which covers 20 initialization cycles plus the 7-cycle latency, and it stays 1 until the next reset.
- R9: Asserting `rstN` low clears every delay-line and output register at once. `dataOut` reads 0 and no code captured before the reset ever reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| stageCodes | input | 12 | 2-bit codes of the six redundant stages, stage i at bits 2i+1:2i |
| flashCode | input | 2 | Code of the final flash stage |
| fmtTwos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| outDisable | input | 1 | 1 requests high impedance on the data pads |
| dataOut | output | 8 | Corrected output word |
| dataDrive | output | 1 | Pad drive enable, 1 means drive |
| dataValid | output | 1 | High once the start-up window has passed |

## Verification
Three things can land on the same clock: a format flip, an output-disable request, and a new word arriving. The bench toggles format every 23 cycles and opens a disable window every 46 cycles, so at cycle 46 and each multiple of it both controls change on the same edge while words keep streaming. Every cycle the bench checks `dataOut` against the word it computes with the format in force at that edge, and checks `dataDrive` against the disable request. Any coupling between the two controls, or any lost word while the output is disabled, shows up as a mismatch.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic twosComp;
    logic drive;
    logic valid;
  } corrCtrl_t;

  // Register depth of lane idx. Two stages share one clock of skew,
  // and every lane, the flash included, is registered at least once.
  function automatic int alignDepth(input int idx, input int nStg);
    return nStg / 2 + 1 - idx / 2;
  endfunction

endpackage

// File: rtl/adc_stage_delay.sv
module adc_stage_delay #(
  parameter int W     = 2,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] pipe [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < DEPTH; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= din;
      for (int k = 1; k < DEPTH; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign dout = pipe[DEPTH-1];

endmodule

// File: rtl/adc_corr_datapath.sv
module adc_corr_datapath
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_STAGES-1:0] stageCodes,
  input  logic [1:0]              flashCode,
  input  corrCtrl_t               ctrl,
  output logic [NUM_STAGES+1:0]   wordOut
);

  localparam int OUT_W  = NUM_STAGES + 2;
  localparam int SUM_W  = NUM_STAGES + 4;
  localparam int OFFSET = (1 << NUM_STAGES) - 1;
  localparam int FULL   = (1 << OUT_W) - 1;

  logic [1:0] rawCode [NUM_STAGES+1];
  logic [1:0] aligned [NUM_STAGES+1];

  // One skewed delay lane per stage, and one for the flash
  for (genvar g = 0; g <= NUM_STAGES; g++) begin : g_lane
    if (g < NUM_STAGES) begin : g_sub
      assign rawCode[g] = stageCodes[2*g +: 2];
    end else begin : g_flash
      assign rawCode[g] = flashCode;
    end
    adc_stage_delay #(
      .W    (2),
      .DEPTH(alignDepth(g, NUM_STAGES))
    ) u_dly (
      .clk (clk),
      .rstN(rstN),
      .din (rawCode[g]),
      .dout(aligned[g])
    );
  end

  logic [SUM_W-1:0] sumNext, sumReg, shifted;
  logic [OUT_W-1:0] satNext, satReg, lvlA, lvlB;

  // Overlapping shift-and-add of the aligned codes
  always_comb begin
    sumNext = SUM_W'(aligned[NUM_STAGES]);
    for (int k = 0; k < NUM_STAGES; k++)
      sumNext = sumNext + (SUM_W'(aligned[k]) << (NUM_STAGES - k));
  end

  // Offset removal and clamp
  always_comb begin
    shifted = sumReg - SUM_W'(OFFSET);
    if (sumReg < SUM_W'(OFFSET))
      satNext = '0;
    else if (shifted > SUM_W'(FULL))
      satNext = '1;
    else
      satNext = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumReg <= '0;
      satReg <= '0;
      lvlA   <= '0;
      lvlB   <= '0;
    end else begin
      sumReg <= sumNext;
      satReg <= satNext;
      lvlA   <= satReg;
      lvlB   <= lvlA ^ {ctrl.twosComp, {(OUT_W-1){1'b0}}};
    end
  end

  assign wordOut = lvlB;

endmodule

// File: rtl/adc_corr_ctrl.sv
module adc_corr_ctrl
  import adc_corr_pkg::*;
#(
  parameter int VALID_AFTER = 27
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      fmtTwos,
  input  logic      outDisable,
  output corrCtrl_t ctrl
);

  localparam int CNT_W = $clog2(VALID_AFTER + 1);

  logic [CNT_W-1:0] upCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      upCnt <= '0;
    else if (upCnt != CNT_W'(VALID_AFTER))
      upCnt <= upCnt + 1'b1;
  end

  always_comb begin
    ctrl.twosComp = fmtTwos;
    ctrl.drive    = !outDisable;
    ctrl.valid    = (upCnt == CNT_W'(VALID_AFTER));
  end

endmodule

// File: rtl/adc_corr_backend.sv
module adc_corr_backend
  import adc_corr_pkg::*;
#(
  parameter int NUM_STAGES  = 6,
  parameter int INIT_CYCLES = 20
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2*NUM_STAGES-1:0] stageCodes,
  input  logic [1:0]              flashCode,
  input  logic                    fmtTwos,
  input  logic                    outDisable,
  output logic [NUM_STAGES+1:0]   dataOut,
  output logic                    dataDrive,
  output logic                    dataValid
);

  // alignment depth of lane 0 plus sum, clamp and two output levels
  localparam int LATENCY     = alignDepth(0, NUM_STAGES) + 3;
  localparam int VALID_AFTER = INIT_CYCLES + LATENCY;

  corrCtrl_t ctrl;

  adc_corr_ctrl #(.VALID_AFTER(VALID_AFTER)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fmtTwos   (fmtTwos),
    .outDisable(outDisable),
    .ctrl      (ctrl)
  );

  adc_corr_datapath #(.NUM_STAGES(NUM_STAGES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stageCodes(stageCodes),
    .flashCode (flashCode),
    .ctrl      (ctrl),
    .wordOut   (dataOut)
  );

  assign dataDrive = ctrl.drive;
  assign dataValid = ctrl.valid;

endmodule

// File: rtl/adc_corr_backend_chk.sv
module adc_corr_backend_chk #(
  parameter int NUM_STAGES  = 6,
  parameter int VALID_AFTER = 27
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [2*NUM_STAGES-1:0] stageCodes,
  input logic [1:0]              flashCode,
  input logic                    fmtTwos,
  input logic [NUM_STAGES+1:0]   dataOut,
  input logic                    dataValid
);

  localparam int OUT_W    = NUM_STAGES + 2;
  localparam int LATENCY  = NUM_STAGES / 2 + 4;
  localparam int RUN_NEED = LATENCY + 1;
  localparam int RUN_W    = $clog2(RUN_NEED + 1) + 1;
  localparam int CNT_W    = $clog2(VALID_AFTER + 1);

  logic [CNT_W-1:0] upCnt;
  logic [RUN_W-1:0] maxRun, minRun;
  logic allMax, allMin;

  assign allMax = (&stageCodes) && (&flashCode);
  assign allMin = (stageCodes == '0) && (flashCode == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upCnt  <= '0;
      maxRun <= '0;
      minRun <= '0;
    end else begin
      if (upCnt != CNT_W'(VALID_AFTER)) upCnt <= upCnt + 1'b1;
      maxRun <= !allMax ? '0 : ((maxRun == '1) ? maxRun : maxRun + 1'b1);
      minRun <= !allMin ? '0 : ((minRun == '1) ? minRun : minRun + 1'b1);
    end
  end

  // R8: flag low during the start-up window
  a_r8_valid_early: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt < CNT_W'(VALID_AFTER)) |-> !dataValid);

  // R8: flag high once the window has passed
  a_r8_valid_late: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt == CNT_W'(VALID_AFTER)) |-> dataValid);

  // R8: flag never drops before a reset
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> dataValid);

  // R3 with R6: a run of all-max codes gives full scale in the selected format
  a_r3_clamp_high: assert property (@(posedge clk) disable iff (!rstN)
    (maxRun >= RUN_W'(RUN_NEED)) |->
      (dataOut == {!$past(fmtTwos), {(OUT_W-1){1'b1}}}));

  // R3 with R6: a run of all-zero codes gives zero scale in the selected format
  a_r3_clamp_low: assert property (@(posedge clk) disable iff (!rstN)
    (minRun >= RUN_W'(RUN_NEED)) |->
      (dataOut == {$past(fmtTwos), {(OUT_W-1){1'b0}}}));

endmodule

bind adc_corr_backend adc_corr_backend_chk #(
  .NUM_STAGES (NUM_STAGES),
  .VALID_AFTER(VALID_AFTER)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stageCodes(stageCodes),
  .flashCode (flashCode),
  .fmtTwos   (fmtTwos),
  .dataOut   (dataOut),
  .dataValid (dataValid)
);

// File: tb/adc_corr_backend_bench.sv
module adc_corr_backend_bench;

  localparam int NS     = 6;
  localparam int NSAMP  = 300;
  localparam int LAT    = 7;
  localparam int VAL_AT = 27;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rstN = 1'b0;
  logic [2*NS-1:0] stageCodes = '0;
  logic [1:0]    flashCode = '0;
  logic          fmtTwos = 1'b0;
  logic          outDisable = 1'b0;
  logic [NS+1:0] dataOut;
  logic          dataDrive;
  logic          dataValid;

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  logic [1:0] smp [NSAMP][NS+1];

  adc_corr_backend u_adc_corr_backend (
    .clk       (clk),
    .rstN      (rstN),
    .stageCodes(stageCodes),
    .flashCode (flashCode),
    .fmtTwos   (fmtTwos),
    .outDisable(outDisable),
    .dataOut   (dataOut),
    .dataDrive (dataDrive),
    .dataValid (dataValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int rawOf(input int m);
    int r = int'(smp[m][NS]) - 63;
    for (int i = 0; i < NS; i++) r += int'(smp[m][i]) << (NS - i);
    return r;
  endfunction

  // R2 R3 R6: expected bus word
  function automatic int expWord(input int m, input bit fmt);
    int r = rawOf(m);
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    if (fmt) r = r ^ 128;
    return r;
  endfunction

  // R1: stage i carries sample t-1-i/2 before edge t; the flash carries sample t-4
  task automatic drive(input int t);
    for (int i = 0; i <= NS; i++) begin
      int n = t - 1 - i / 2;
      logic [1:0] c = (n >= 0 && n < NSAMP) ? smp[n][i] : 2'b00;
      if (i < NS) stageCodes[2*i +: 2] = c;
      else flashCode = c;
    end
    fmtTwos    = ((t / 23) % 2) == 1;
    outDisable = (t % 46) < 4;
  endtask

  task automatic checkEdge(input int t);
    int m = t - 1 - LAT;
    chk("R8 valid timing", int'(dataValid), (t >= VAL_AT) ? 1 : 0);
    chk("R7 drive enable", int'(dataDrive), outDisable ? 0 : 1);
    // R1 R4 R5: word of sample m after edge m+8, one new word per clock
    if (m >= 0 && m < NSAMP) begin
      int r = rawOf(m);
      string tag = (r < 0 || r > 255) ? "R3 clamp" : (fmtTwos ? "R6 twos format" : "R2 merge");
      chk(tag, int'(dataOut), expWord(m, fmtTwos));
    end
  endtask

  task automatic setSample(input int n, input int c0, input int c1, input int cf);
    smp[n][0] = 2'(c0);
    for (int i = 1; i < NS; i++) smp[n][i] = 2'(c1);
    smp[n][NS] = 2'(cf);
  endtask

  initial begin
    for (int n = 0; n < NSAMP; n++)
      for (int i = 0; i <= NS; i++)
        smp[n][i] = 2'(((n * 7 + i * 5 + (n >> 2) * (i + 1)) >> 1) % 4);
    setSample(0, 1, 1, 1);  // 64
    setSample(1, 0, 1, 1);  // raw 0
    setSample(2, 0, 1, 0);  // raw -1
    setSample(3, 3, 2, 2);  // raw 255
    setSample(4, 3, 2, 3);  // raw 256
    setSample(5, 2, 2, 2);  // 191
    setSample(6, 3, 3, 3);  // 318
    setSample(7, 0, 0, 0);  // -63
    for (int n = 20; n < 36; n++) setSample(n, 3, 3, 3);
    for (int n = 40; n < 56; n++) setSample(n, 0, 0, 0);

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset word", int'(dataOut), 0);
    chk("R8 reset valid", int'(dataValid), 0);
    rstN = 1'b1;

    for (int t = 1; t <= NSAMP + 10; t++) begin
      drive(t);
      @(posedge clk);
      @(negedge clk);
      checkEdge(t);
    end

    // Fill every lane with full-scale codes, then reset mid-stream
    stageCodes = '1;
    flashCode  = 2'b11;
    fmtTwos    = 1'b0;
    outDisable = 1'b0;
    repeat (10) @(negedge clk);
    chk("R3 full scale", int'(dataOut), 255);
    rstN = 1'b0;
    #1;
    chk("R9 async clear", int'(dataOut), 0);
    chk("R8 clear valid", int'(dataValid), 0);
    stageCodes = '0;
    flashCode  = 2'b00;
    @(negedge clk);
    rstN = 1'b1;
    for (int t = 1; t <= 30; t++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9 no stale code", int'(dataOut), 0);
      chk("R8 valid after reset", int'(dataValid), (t >= VAL_AT) ? 1 : 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule